// File: doc/BRIEF.md
# Keyboard Port Trap and Gate-A20 Pass-Through

This block watches the decoded I/O accesses that target the two legacy keyboard-controller ports (60h and 64h). Each kind of access sets a sticky status flag in a 32-bit control/status register. The block raises a system-management interrupt request whenever a set flag also has its enable set. The SMI handler reads the register to find the cause and clears the flags by writing ones.

When pass-through is enabled, the block also recognises the short command sequence that old software uses to switch the A20 address gate. The sequence is a D1h command write to port 64h, then a data write to port 60h, then an FFh write to port 64h. These writes complete without trapping. The data write drives the A20GATE output directly. When the sequence finishes, an end-of-pass-through flag is set, and it can raise a deferred SMI.

Top module: `kbc_trap_smi`

## Requirements
- R1: An access to the ports sets a sticky trap flag at register bit 8 + {port64, write}: bit 8 is a 60h read, bit 9 a 60h write, bit 10 a 64h read and bit 11 a 64h write. The flag is set on the clock edge that samples the access, whatever its enable holds.
- R2: Writing 1 to a status bit (bits 11:8 or 15) clears it. Writing 0 leaves it unchanged.
- R3: When an access sets a trap flag in the same cycle that a register write clears it, the flag stays set.
- R4: `smi_req` is high exactly while some status bit is set together with its enable. The enables for bits 8..11 are at bits 0..3, and the enable for bit 15 is at bit 7. The request stays high until software clears the responsible flags.
- R5: With pass-through enabled (bit 5 = 1), a write of D1h to port 64h starts the sequence. Bit 6 then reads 1. The writes that belong to the sequence set no trap flag and raise no SMI.
- R6: The 60h data write inside the sequence loads bit 1 of its data into `a20gate` at that clock edge. `a20gate` resets to 0 and changes at no other time.
- R7: A write of FFh to port 64h while the sequence waits for its end returns bit 6 to 0 and sets bit 15. That raises an SMI only when bit 7 is 1.
- R8: Any other 60h/64h access in the middle of the sequence aborts it. Bit 6 returns to 0, bit 15 stays clear, and that access is trapped as in R1.
- R9: A register write with bit 5 = 0 returns the sequence to idle, and bit 6 reads 0 after that edge.
- R10: Bits 31:16, 14 and 12 read 0 and ignore writes. Bits 13 and 4 are read/write and reset to 1. Every other bit resets to 0, so the reset value is 0000_2010h.
- R11: With pass-through disabled, D1h and FFh writes to port 64h are trapped like any other write and do not change bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | One-cycle strobe for a decoded keyboard-port access |
| acc_port64 | input | 1 | 1 selects port 64h, 0 selects port 60h |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_data | input | 8 | Write data of the access |
| reg_wr | input | 1 | Control/status register write strobe |
| reg_wdata | input | 32 | Control/status register write data |
| reg_rdata | output | 32 | Control/status register read value |
| a20gate | output | 1 | Address gate A20 level |
| smi_req | output | 1 | SMI request level |

## Verification
A wrong sequence state shows up in bit 6 of the read value on the edge right after the access that should have moved it. It also shows up as a trap flag that is set or missing on that same edge, because suppression and trapping are decided in one cycle. A lost or stuck sticky flag shows up at once in the read value and in `smi_req` once the matching enable is set. A wrong `a20gate` load shows up directly on the pin the cycle after the 60h data write. Every scenario ends with a read-back, so a fault cannot stay hidden past the next comparison.

// File: rtl/kbc_trap_pkg.sv
package kbc_trap_pkg;
  localparam int REG_W       = 32;
  localparam int DATA_W      = 8;
  localparam int NUM_TRAP    = 4;
  localparam int TRAP_IDX_W  = $clog2(NUM_TRAP);
  localparam int EN_LSB      = 0;
  localparam int RSV_LO_BIT  = 4;
  localparam int PASS_EN_BIT = 5;
  localparam int PSTATE_BIT  = 6;
  localparam int END_EN_BIT  = 7;
  localparam int STS_LSB     = 8;
  localparam int RSV_HI_BIT  = 13;
  localparam int END_STS_BIT = 15;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WAIT_DATA = 2'd1,
    SEQ_WAIT_END  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/kbc_trap_sticky.sv
module kbc_trap_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_comb begin
      q_d[gi] = q_q[gi];
      if (clr_i[gi]) q_d[gi] = 1'b0;
      if (set_i[gi]) q_d[gi] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q[gi] <= 1'b0;
      else        q_q[gi] <= q_d[gi];
    end

    // R1 / R3: an event always leaves the flag set
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[gi] |=> q_q[gi]);
    // R2: clear without a competing event drops the flag
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[gi] && !set_i[gi]) |=> !q_q[gi]);
    // R2: without set or clear the flag holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[gi] && !set_i[gi]) |=> $stable(q_q[gi]));
  end

  assign q_o = q_q;
endmodule

// File: rtl/kbc_trap_ctl.sv
module kbc_trap_ctl
  import kbc_trap_pkg::*;
#(
  parameter int NT = NUM_TRAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [NT-1:0]    trap_en_o,
  output logic             end_en_o,
  output logic             pass_en_o,
  output logic             rsv_lo_o,
  output logic             rsv_hi_o,
  output logic             pass_kill_o
);
  logic [NT-1:0] trap_en_d, trap_en_q;
  logic          end_en_d, end_en_q;
  logic          pass_en_d, pass_en_q;
  logic          rsv_lo_d, rsv_lo_q;
  logic          rsv_hi_d, rsv_hi_q;
  logic          unused_wbits;

  assign unused_wbits = ^{reg_wdata[REG_W-1:RSV_HI_BIT+1],
                          reg_wdata[RSV_HI_BIT-1:STS_LSB],
                          reg_wdata[PSTATE_BIT]};

  always_comb begin
    trap_en_d = trap_en_q;
    end_en_d  = end_en_q;
    pass_en_d = pass_en_q;
    rsv_lo_d  = rsv_lo_q;
    rsv_hi_d  = rsv_hi_q;
    if (reg_wr) begin
      trap_en_d = reg_wdata[EN_LSB +: NT];
      end_en_d  = reg_wdata[END_EN_BIT];
      pass_en_d = reg_wdata[PASS_EN_BIT];
      rsv_lo_d  = reg_wdata[RSV_LO_BIT];
      rsv_hi_d  = reg_wdata[RSV_HI_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q <= '0;
      end_en_q  <= 1'b0;
      pass_en_q <= 1'b0;
      rsv_lo_q  <= 1'b1;
      rsv_hi_q  <= 1'b1;
    end else begin
      trap_en_q <= trap_en_d;
      end_en_q  <= end_en_d;
      pass_en_q <= pass_en_d;
      rsv_lo_q  <= rsv_lo_d;
      rsv_hi_q  <= rsv_hi_d;
    end
  end

  assign trap_en_o   = trap_en_q;
  assign end_en_o    = end_en_q;
  assign pass_en_o   = pass_en_q;
  assign rsv_lo_o    = rsv_lo_q;
  assign rsv_hi_o    = rsv_hi_q;
  assign pass_kill_o = reg_wr && !reg_wdata[PASS_EN_BIT];

  // R10: control fields move only on a register write
  a_r10_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable({trap_en_q, end_en_q, pass_en_q, rsv_lo_q, rsv_hi_q}));
endmodule

// File: rtl/kbc_trap_a20seq.sv
module kbc_trap_a20seq
  import kbc_trap_pkg::*;
#(
  parameter int                DW        = DATA_W,
  parameter logic [DW-1:0]     CMD_START = 8'hD1,
  parameter logic [DW-1:0]     CMD_END   = 8'hFF,
  parameter int                A20_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic          acc_port64,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_data,
  input  logic          pass_en,
  input  logic          pass_kill,
  output logic          suppress_o,
  output logic          seq_done_o,
  output logic          pstate_o,
  output logic          a20gate_o
);
  seq_state_e state_d, state_q;
  logic       a20_d, a20_q;
  logic       a20_load;
  logic       is_w64, is_w60;

  assign is_w64 = acc_port64 && acc_wr;
  assign is_w60 = !acc_port64 && acc_wr;

  always_comb begin
    state_d    = state_q;
    suppress_o = 1'b0;
    seq_done_o = 1'b0;
    a20_load   = 1'b0;
    if (acc_vld) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (is_w64 && acc_data == CMD_START) begin
            suppress_o = 1'b1;
            state_d    = SEQ_WAIT_DATA;
          end
        end
        SEQ_WAIT_DATA: begin
          if (is_w60) begin
            suppress_o = 1'b1;
            a20_load   = 1'b1;
            state_d    = SEQ_WAIT_END;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
        SEQ_WAIT_END: begin
          if (is_w64 && acc_data == CMD_END) begin
            suppress_o = 1'b1;
            seq_done_o = 1'b1;
          end
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
    if (!pass_en || pass_kill) begin
      state_d    = SEQ_IDLE;
      suppress_o = 1'b0;
      seq_done_o = 1'b0;
      a20_load   = 1'b0;
    end
  end

  always_comb begin
    a20_d = a20_q;
    if (a20_load) a20_d = acc_data[A20_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      a20_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      a20_q   <= a20_d;
    end
  end

  assign pstate_o  = (state_q != SEQ_IDLE);
  assign a20gate_o = a20_q;

  // R6: the gate only moves out of the data-wait state
  a_r6_a20_only_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_WAIT_DATA) |=> $stable(a20_q));
  // R5: no suppression unless pass-through is on
  a_r5_suppress_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_o |-> pass_en);
  // R9: a write clearing the enable sends the sequence idle
  a_r9_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_kill |=> (state_q == SEQ_IDLE));
  // R7: completion only from the end-wait state
  a_r7_done_from_end: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (state_q == SEQ_WAIT_END));
endmodule

// File: rtl/kbc_trap_smi.sv
module kbc_trap_smi
  import kbc_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_port64,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              a20gate,
  output logic              smi_req
);
  logic [NUM_TRAP-1:0] trap_en, trap_set, trap_clr, trap_sts;
  logic                end_en, pass_en, rsv_lo, rsv_hi, pass_kill;
  logic                seq_suppress, seq_done, pstate;
  logic [0:0]          end_set, end_clr, end_sts;
  logic [TRAP_IDX_W-1:0] acc_idx;

  kbc_trap_ctl #(.NT(NUM_TRAP)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .trap_en_o   (trap_en),
    .end_en_o    (end_en),
    .pass_en_o   (pass_en),
    .rsv_lo_o    (rsv_lo),
    .rsv_hi_o    (rsv_hi),
    .pass_kill_o (pass_kill)
  );

  kbc_trap_a20seq #(.DW(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_port64 (acc_port64),
    .acc_wr     (acc_wr),
    .acc_data   (acc_data),
    .pass_en    (pass_en),
    .pass_kill  (pass_kill),
    .suppress_o (seq_suppress),
    .seq_done_o (seq_done),
    .pstate_o   (pstate),
    .a20gate_o  (a20gate)
  );

  assign acc_idx = {acc_port64, acc_wr};

  for (genvar gi = 0; gi < NUM_TRAP; gi++) begin : g_trap_dec
    assign trap_set[gi] = acc_vld && !seq_suppress && (acc_idx == TRAP_IDX_W'(gi));
    assign trap_clr[gi] = reg_wr && reg_wdata[STS_LSB + gi];
  end

  kbc_trap_sticky #(.W(NUM_TRAP)) u_trap_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (trap_set),
    .clr_i (trap_clr),
    .q_o   (trap_sts)
  );

  assign end_set = seq_done;
  assign end_clr = reg_wr && reg_wdata[END_STS_BIT];

  kbc_trap_sticky #(.W(1)) u_end_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (end_set),
    .clr_i (end_clr),
    .q_o   (end_sts)
  );

  assign smi_req = (|(trap_sts & trap_en)) || (end_sts[0] && end_en);

  always_comb begin
    reg_rdata                             = '0;
    reg_rdata[EN_LSB +: NUM_TRAP]         = trap_en;
    reg_rdata[RSV_LO_BIT]                 = rsv_lo;
    reg_rdata[PASS_EN_BIT]                = pass_en;
    reg_rdata[PSTATE_BIT]                 = pstate;
    reg_rdata[END_EN_BIT]                 = end_en;
    reg_rdata[STS_LSB +: NUM_TRAP]        = trap_sts;
    reg_rdata[RSV_HI_BIT]                 = rsv_hi;
    reg_rdata[END_STS_BIT]                = end_sts[0];
  end

  // R4: no request without a set flag
  a_r4_smi_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_sts == '0 && !end_sts[0]) |-> !smi_req);
  // R1: an unsuppressed access leaves some trap flag set
  a_r1_access_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !seq_suppress) |=> (trap_sts != '0));
  // R5: a suppressed access leaves the trap flags untouched unless cleared
  a_r5_suppressed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && seq_suppress && !reg_wr) |=> $stable(trap_sts));
  // R10: reserved read-zero bits
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[REG_W-1:16] == '0) && !reg_rdata[14] && !reg_rdata[12]);
  // R7: end flag rises only as a sequence leaves its wait
  a_r7_end_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_sts[0]) |-> $past(pstate));
endmodule

// File: tb/test_kbc_trap_smi.sv
`timescale 1ns/1ps
module test_kbc_trap_smi;
  logic        clk;
  logic        rst_n;
  logic        acc_vld, acc_port64, acc_wr;
  logic [7:0]  acc_data;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        a20gate, smi_req;

  typedef struct {
    logic [31:0] rd;
    logic        smi;
    logic        a20;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  kbc_trap_smi i_kbc_trap_smi (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_port64(acc_port64),
    .acc_wr(acc_wr), .acc_data(acc_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .a20gate(a20gate), .smi_req(smi_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (reg_rdata !== e.rd || smi_req !== e.smi || a20gate !== e.a20) begin
        n_bad++;
        $display("FAIL %s: rdata=%h smi=%b a20=%b expected rdata=%h smi=%b a20=%b",
                 e.tag, reg_rdata, smi_req, a20gate, e.rd, e.smi, e.a20);
      end
    end
  end

  task automatic expect_out(input logic [31:0] rd, input logic smi, input logic a20,
                            input string tag);
    exp_t e;
    e.rd = rd; e.smi = smi; e.a20 = a20; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic acc(input logic p64, input logic wr, input logic [7:0] d);
    @(negedge clk);
    acc_vld = 1'b1; acc_port64 = p64; acc_wr = wr; acc_data = d;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic wreg(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic acc_and_wreg(input logic p64, input logic wr, input logic [7:0] d,
                              input logic [31:0] w);
    @(negedge clk);
    acc_vld = 1'b1; acc_port64 = p64; acc_wr = wr; acc_data = d;
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    acc_vld = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_vld = 1'b0; acc_port64 = 1'b0; acc_wr = 1'b0; acc_data = '0;
    reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(32'h0000_2010, 0, 0, "R10 reset value");

    wreg(32'hFFFF_FFFF);
    expect_out(32'h0000_20BF, 0, 0, "R10 reserved bits ignore writes");
    wreg(32'h0000_0000);
    expect_out(32'h0000_0000, 0, 0, "R10 bits 13 and 4 writable");
    wreg(32'h0000_2010);

    acc(0, 0, 8'h00);
    expect_out(32'h0000_2110, 0, 0, "R1 60h read without enable");
    acc(0, 1, 8'h00);
    expect_out(32'h0000_2310, 0, 0, "R1 60h write");
    acc(1, 0, 8'h00);
    expect_out(32'h0000_2710, 0, 0, "R1 64h read");
    acc(1, 1, 8'h12);
    expect_out(32'h0000_2F10, 0, 0, "R1 64h write");
    wreg(32'h0000_2110);
    expect_out(32'h0000_2E10, 0, 0, "R2 clear one flag only");
    wreg(32'h0000_2E10);
    expect_out(32'h0000_2010, 0, 0, "R2 clear remaining flags");

    wreg(32'h0000_2011);
    acc(0, 0, 8'h00);
    expect_out(32'h0000_2111, 1, 0, "R4 enabled flag requests SMI");
    acc(1, 0, 8'h00);
    expect_out(32'h0000_2511, 1, 0, "R4 second flag");
    wreg(32'h0000_2111);
    expect_out(32'h0000_2411, 0, 0, "R4 request drops when enabled flag cleared");
    wreg(32'h0000_2410);

    acc(0, 1, 8'h00);
    acc_and_wreg(0, 1, 8'h00, 32'h0000_2210);
    expect_out(32'h0000_2210, 0, 0, "R3 event beats clear");
    wreg(32'h0000_2210);
    expect_out(32'h0000_2010, 0, 0, "R2 clear after collision");

    wreg(32'h0000_20BF);
    acc(1, 1, 8'hD1);
    expect_out(32'h0000_20FF, 0, 0, "R5 start command enters sequence");
    acc(0, 1, 8'h02);
    expect_out(32'h0000_20FF, 0, 1, "R6 data write drives gate high");
    acc(1, 1, 8'hFF);
    expect_out(32'h0000_A0BF, 1, 1, "R7 end sets bit 15 and SMI");
    wreg(32'h0000_A0BF);
    expect_out(32'h0000_20BF, 0, 1, "R2 end flag cleared");

    wreg(32'h0000_203F);
    acc(1, 1, 8'hD1);
    acc(0, 1, 8'h00);
    expect_out(32'h0000_207F, 0, 0, "R6 data write drives gate low");
    acc(1, 1, 8'hFF);
    expect_out(32'h0000_A03F, 0, 0, "R7 end without end-enable");
    wreg(32'h0000_A03F);

    acc(1, 1, 8'hD1);
    acc(0, 0, 8'h00);
    expect_out(32'h0000_213F, 1, 0, "R8 read aborts data wait and traps");
    wreg(32'h0000_213F);
    acc(1, 1, 8'hD1);
    acc(0, 1, 8'h02);
    acc(1, 1, 8'h55);
    expect_out(32'h0000_283F, 1, 1, "R8 wrong end byte aborts and traps");
    wreg(32'h0000_283F);

    acc(1, 1, 8'hD1);
    wreg(32'h0000_201F);
    expect_out(32'h0000_201F, 0, 1, "R9 disabling pass-through idles");
    acc(0, 1, 8'h00);
    expect_out(32'h0000_221F, 1, 1, "R6 gate holds outside sequence");
    wreg(32'h0000_221F);

    acc(1, 1, 8'hD1);
    expect_out(32'h0000_281F, 1, 1, "R11 start command trapped when disabled");
    wreg(32'h0000_281F);
    acc(1, 1, 8'hFF);
    expect_out(32'h0000_281F, 1, 1, "R11 end command trapped when disabled");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule